// File: doc/BRIEF.md
# Static Branch Direction Guesser with Wrong-Path Squash

This block steers instruction fetch for a four-stage in-order pipeline made of fetch, decode, execute and write-back. For each conditional branch presented at fetch it makes a fixed direction guess. In the default mode the guess follows the sign of the branch displacement. Jumps to a lower or equal address are guessed taken and jumps to a higher address are guessed not taken. A per-instruction compiler hint can replace that guess. Two forcing modes guess every branch taken or every branch not taken. The guess selects the next fetch address.

The branch condition is known only in execute, and the datapath reports it on `ex_taken`. When the actual outcome differs from the guess, the block discards the two younger instructions, which are the one in decode and the one being fetched, and restarts fetch at the correct address. The branch itself carries on to write-back. Two saturating counters record resolved branches and mispredictions, so accuracy can be measured.

Top module: `bp_frontend`

## Requirements
- R1: With `guess_mode` set to 2'b00 or 2'b11 and `fe_hint_en` low, a valid branch with a negative or zero `fe_disp` is guessed taken, and one with a positive `fe_disp` is guessed not taken. `fetch_pred_taken` is high only for valid branches guessed taken.
- R2: In modes 2'b00 and 2'b11, a valid branch with `fe_hint_en` high is guessed in the direction given by `fe_hint_dir` (1 = taken), whatever the sign of its displacement.
- R3: Mode 2'b01 guesses every valid branch taken and mode 2'b10 guesses every valid branch not taken. Hint inputs have no effect in these two modes.
- R4: Without a misprediction, the next `fetch_pc` is `fetch_pc + fe_disp` (sign-extended) for a slot guessed taken and `fetch_pc + INSN_BYTES` otherwise. With `fe_valid` low, `fetch_pc` holds and a bubble enters decode.
- R5: A valid branch reaches execute two cycles after it is fetched. `flush` is high during the cycle in which that branch is in execute with `ex_taken` different from its guess, and low in every other cycle.
- R6: In the cycle after `flush`, `de_valid` and `ex_valid` are low, and the mispredicted branch appears at write-back with `wb_valid` high and `wb_pc` set to its address.
- R7: While `flush` is high, `redirect_pc` is the branch target if the branch was taken and the branch address plus `INSN_BYTES` if not. In the next cycle `fetch_pc` equals that value, even when the slot in fetch was guessed taken.
- R8: Both kinds of misprediction, guessed taken but not taken and guessed not taken but taken, squash exactly the same two slots.
- R9: `branch_count` increases by one for each valid branch in execute and `mispredict_count` increases by one for each flush. Both stop at their all-ones value.
- R10: After a synchronous active-low reset, `fetch_pc` equals `RESET_PC`, all stage valid flags are low and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| guess_mode | input | 2 | 00/11 sign rule with hint, 01 all taken, 10 all not taken |
| fe_valid | input | 1 | An instruction is present at `fetch_pc` |
| fe_is_branch | input | 1 | Fetched instruction is a conditional branch |
| fe_disp | input | DISP_W | Signed byte displacement of the fetched branch |
| fe_hint_en | input | 1 | Fetched branch carries a direction hint |
| fe_hint_dir | input | 1 | Hinted direction, 1 = taken |
| ex_taken | input | 1 | Actual outcome of the branch in execute |
| fetch_pc | output | ADDR_W | Address being fetched this cycle |
| fetch_pred_taken | output | 1 | Fetch slot holds a branch guessed taken |
| de_valid | output | 1 | Decode slot holds a live instruction |
| ex_valid | output | 1 | Execute slot holds a live instruction |
| ex_pc | output | ADDR_W | Address of the instruction in execute |
| ex_is_branch | output | 1 | Execute slot is a conditional branch |
| wb_valid | output | 1 | Write-back slot holds a live instruction |
| wb_pc | output | ADDR_W | Address of the instruction in write-back |
| flush | output | 1 | Misprediction found in execute this cycle |
| redirect_pc | output | ADDR_W | Corrected fetch address while `flush` is high |
| branch_count | output | CNT_W | Saturating count of resolved branches |
| mispredict_count | output | CNT_W | Saturating count of mispredictions |

## Verification
The bench builds the block with a 16-bit address, an 8-bit displacement, 4-byte instructions and 4-bit counters. The narrow counters reach saturation within a few dozen branches, so the all-ones hold is exercised well before a mid-run reset clears both counts. The small displacement range produces backward, forward and self-targeting branches in every mode, and random outcomes give many mispredictions of both kinds. These include cases where a squash coincides with a taken guess in fetch.

// File: rtl/bp_pkg.sv
// Package: shared definitions for the static branch front end.
// Assumes: the guess-mode encoding is fixed by the configuration input of the top.
package bp_pkg;

    // Direction guessing policy selected by the configuration input.
    typedef enum logic [1:0] {
        GUESS_SIGN     = 2'b00,
        GUESS_TAKEN    = 2'b01,
        GUESS_NOTTAKEN = 2'b10,
        GUESS_SIGN_ALT = 2'b11
    } guess_mode_e;

    // Pipeline geometry: index of execute among the post-fetch stages.
    localparam int EX_STAGE_IDX = 1;

endpackage

// File: rtl/bp_guess.sv
// Module: static direction guess for the instruction in fetch.
// Does: applies the sign rule (zero counts as backward) or the compiler hint,
//       or forces the direction when a forcing mode is selected.
// Assumes: disp_i is a two's-complement byte displacement; non-branches guess not taken.
module bp_guess
    import bp_pkg::*;
#(
    parameter int DISP_W = 16
) (
    input  guess_mode_e       mode_i,
    input  logic              is_branch_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic              hint_en_i,
    input  logic              hint_dir_i,
    output logic              taken_o
);

    logic backward;

    // Backward or self-targeting displacement.
    assign backward = disp_i[DISP_W-1] || (disp_i == '0);

    // Select the guess according to the active policy.
    always_comb begin
        taken_o = 1'b0;
        if (is_branch_i) begin
            case (mode_i)
                GUESS_TAKEN:    taken_o = 1'b1;
                GUESS_NOTTAKEN: taken_o = 1'b0;
                default:        taken_o = hint_en_i ? hint_dir_i : backward;
            endcase
        end
    end

endmodule

// File: rtl/bp_fetch_pc.sv
// Module: fetch address register and next-address selection.
// Does: holds the fetch address; a redirect from execute outranks the fetch guess.
// Assumes: DISP_W < ADDR_W; a stalled (invalid) fetch slot keeps the address.
module bp_fetch_pc #(
    parameter int              ADDR_W     = 32,
    parameter int              DISP_W     = 16,
    parameter int              INSN_BYTES = 4,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fe_valid_i,
    input  logic              guess_taken_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic              redirect_en_i,
    input  logic [ADDR_W-1:0] redirect_pc_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] target_o
);

    localparam int              EXT_W = ADDR_W - DISP_W;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_d;
    logic [ADDR_W-1:0] seq_pc;

    // Branch target and sequential successor of the current fetch address.
    assign target_o = pc_q + {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    assign seq_pc   = pc_q + STEP;

    // Next address: redirect, hold, guessed target, or fall-through.
    always_comb begin
        if (redirect_en_i)       pc_d = redirect_pc_i;
        else if (!fe_valid_i)    pc_d = pc_q;
        else if (guess_taken_i)  pc_d = target_o;
        else                     pc_d = seq_pc;
    end

    // Fetch address register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= RESET_PC;
        else        pc_q <= pc_d;
    end

    assign pc_o = pc_q;

endmodule

// File: rtl/bp_stage_pipe.sv
// Module: slot registers for decode, execute and write-back.
// Does: shifts slots one stage per cycle; kill_i clears every slot that is
//       younger than execute (the entering fetch slot and the decode slot).
// Assumes: no stalls; kill_i is raised only for a live branch in execute.
module bp_stage_pipe #(
    parameter int ADDR_W = 32,
    parameter int EX_IDX = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kill_i,
    input  logic              fe_valid_i,
    input  logic [ADDR_W-1:0] fe_pc_i,
    input  logic              fe_branch_i,
    input  logic              fe_guess_i,
    input  logic [ADDR_W-1:0] fe_target_i,
    output logic              de_valid_o,
    output logic              ex_valid_o,
    output logic [ADDR_W-1:0] ex_pc_o,
    output logic              ex_branch_o,
    output logic              ex_guess_o,
    output logic [ADDR_W-1:0] ex_target_o,
    output logic              wb_valid_o,
    output logic [ADDR_W-1:0] wb_pc_o
);

    localparam int STAGES = EX_IDX + 2;
    localparam int CTRL_N = EX_IDX + 1;

    logic              v_a   [STAGES];
    logic [ADDR_W-1:0] pc_a  [STAGES];
    logic              br_a  [CTRL_N];
    logic              gs_a  [CTRL_N];
    logic [ADDR_W-1:0] tg_a  [CTRL_N];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        localparam bit KILLABLE = (s <= EX_IDX);
        logic              v_in;
        logic [ADDR_W-1:0] pc_in;
        logic              v_r;
        logic [ADDR_W-1:0] pc_r;

        if (s == 0) begin : g_head
            assign v_in  = fe_valid_i;
            assign pc_in = fe_pc_i;
        end else begin : g_body
            assign v_in  = v_a[s-1];
            assign pc_in = pc_a[s-1];
        end

        // Valid flag: shifted in, cleared on a squash for younger slots.
        always_ff @(posedge clk) begin
            if (!rst_n) v_r <= 1'b0;
            else        v_r <= v_in && !(KILLABLE && kill_i);
        end

        // Slot address.
        always_ff @(posedge clk) begin
            if (!rst_n) pc_r <= '0;
            else        pc_r <= pc_in;
        end

        assign v_a[s]  = v_r;
        assign pc_a[s] = pc_r;

        if (s < CTRL_N) begin : g_ctrl
            logic              br_in, gs_in;
            logic [ADDR_W-1:0] tg_in;
            logic              br_r, gs_r;
            logic [ADDR_W-1:0] tg_r;

            if (s == 0) begin : g_src_fe
                assign br_in = fe_branch_i;
                assign gs_in = fe_guess_i;
                assign tg_in = fe_target_i;
            end else begin : g_src_prev
                assign br_in = br_a[s-1];
                assign gs_in = gs_a[s-1];
                assign tg_in = tg_a[s-1];
            end

            // Branch attributes carried toward execute.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    br_r <= 1'b0;
                    gs_r <= 1'b0;
                    tg_r <= '0;
                end else begin
                    br_r <= br_in;
                    gs_r <= gs_in;
                    tg_r <= tg_in;
                end
            end

            assign br_a[s] = br_r;
            assign gs_a[s] = gs_r;
            assign tg_a[s] = tg_r;
        end
    end

    assign de_valid_o  = v_a[0];
    assign ex_valid_o  = v_a[EX_IDX];
    assign ex_pc_o     = pc_a[EX_IDX];
    assign ex_branch_o = br_a[EX_IDX];
    assign ex_guess_o  = gs_a[EX_IDX];
    assign ex_target_o = tg_a[EX_IDX];
    assign wb_valid_o  = v_a[STAGES-1];
    assign wb_pc_o     = pc_a[STAGES-1];

    // R6: a squash leaves decode and execute empty in the next cycle.
    assert_flush_bubbles_R6: assert property (@(posedge clk) disable iff (!rst_n)
        kill_i |=> (!de_valid_o && !ex_valid_o));

    // R6: the mispredicted branch itself retires to write-back.
    assert_branch_retires_R6: assert property (@(posedge clk) disable iff (!rst_n)
        kill_i |=> (wb_valid_o && wb_pc_o == $past(ex_pc_o)));

endmodule

// File: rtl/bp_sat_counter.sv
// Module: saturating event counter.
// Does: counts cycles with inc_i high and stops at all ones.
// Assumes: synchronous active-low reset clears the count.
module bp_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;

    // Increment unless already at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (inc_i && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R9: a saturated count never wraps.
    assert_saturate_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == TOP) |=> (cnt_q == TOP));

    // R9: an idle cycle leaves the count unchanged.
    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(cnt_q));

endmodule

// File: rtl/bp_frontend.sv
// Module: static branch predictor front end for a four-stage in-order pipeline.
// Does: guesses branch direction at fetch, steers the fetch address, checks the
//       guess in execute, squashes the two younger slots on a mismatch and
//       redirects fetch; counts resolved branches and mispredictions.
// Assumes: ex_taken is valid whenever a branch occupies execute; no stalls.
module bp_frontend
    import bp_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                DISP_W     = 16,
    parameter int                INSN_BYTES = 4,
    parameter int                CNT_W      = 16,
    parameter logic [ADDR_W-1:0] RESET_PC   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        guess_mode,
    input  logic              fe_valid,
    input  logic              fe_is_branch,
    input  logic [DISP_W-1:0] fe_disp,
    input  logic              fe_hint_en,
    input  logic              fe_hint_dir,
    input  logic              ex_taken,
    output logic [ADDR_W-1:0] fetch_pc,
    output logic              fetch_pred_taken,
    output logic              de_valid,
    output logic              ex_valid,
    output logic [ADDR_W-1:0] ex_pc,
    output logic              ex_is_branch,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_pc,
    output logic              flush,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic [CNT_W-1:0]  branch_count,
    output logic [CNT_W-1:0]  mispredict_count
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    guess_mode_e       mode_e;
    logic              raw_guess;
    logic              fe_guess;
    logic [ADDR_W-1:0] fe_target;
    logic              ex_guess;
    logic [ADDR_W-1:0] ex_target;
    logic              resolve;
    logic              mispredict;

    assign mode_e = guess_mode_e'(guess_mode);

    bp_guess #(.DISP_W(DISP_W)) u_guess (
        .mode_i      (mode_e),
        .is_branch_i (fe_is_branch),
        .disp_i      (fe_disp),
        .hint_en_i   (fe_hint_en),
        .hint_dir_i  (fe_hint_dir),
        .taken_o     (raw_guess)
    );

    // A guess only matters for a live branch in fetch.
    assign fe_guess         = fe_valid && fe_is_branch && raw_guess;
    assign fetch_pred_taken = fe_guess;

    bp_fetch_pc #(
        .ADDR_W     (ADDR_W),
        .DISP_W     (DISP_W),
        .INSN_BYTES (INSN_BYTES),
        .RESET_PC   (RESET_PC)
    ) u_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .fe_valid_i    (fe_valid),
        .guess_taken_i (fe_guess),
        .disp_i        (fe_disp),
        .redirect_en_i (mispredict),
        .redirect_pc_i (redirect_pc),
        .pc_o          (fetch_pc),
        .target_o      (fe_target)
    );

    bp_stage_pipe #(
        .ADDR_W (ADDR_W),
        .EX_IDX (EX_STAGE_IDX)
    ) u_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .kill_i      (mispredict),
        .fe_valid_i  (fe_valid),
        .fe_pc_i     (fetch_pc),
        .fe_branch_i (fe_is_branch),
        .fe_guess_i  (fe_guess),
        .fe_target_i (fe_target),
        .de_valid_o  (de_valid),
        .ex_valid_o  (ex_valid),
        .ex_pc_o     (ex_pc),
        .ex_branch_o (ex_is_branch),
        .ex_guess_o  (ex_guess),
        .ex_target_o (ex_target),
        .wb_valid_o  (wb_valid),
        .wb_pc_o     (wb_pc)
    );

    // Resolution in execute: compare actual outcome with the carried guess.
    assign resolve     = ex_valid && ex_is_branch;
    assign mispredict  = resolve && (ex_taken != ex_guess);
    assign flush       = mispredict;
    assign redirect_pc = ex_taken ? ex_target : (ex_pc + STEP);

    bp_sat_counter #(.W(CNT_W)) u_branch_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (resolve),
        .cnt_o (branch_count)
    );

    bp_sat_counter #(.W(CNT_W)) u_miss_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (mispredict),
        .cnt_o (mispredict_count)
    );

    // R7: fetch resumes at the corrected address, outranking any fetch guess.
    assert_redirect_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |=> (fetch_pc == $past(redirect_pc)));

    // R4: a taken guess without a squash moves fetch to the branch target.
    assert_follow_guess_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_guess && !mispredict) |=> (fetch_pc == $past(fe_target)));

    // R4: an empty fetch slot holds the fetch address.
    assert_hold_on_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fe_valid && !mispredict) |=> $stable(fetch_pc));

    // R1: backward branch without a hint is followed in sign mode.
    assert_backward_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (guess_mode == 2'b00 && fe_valid && fe_is_branch && !fe_hint_en &&
         fe_disp[DISP_W-1] && !mispredict) |=> (fetch_pc == $past(fe_target)));

    // R3: the never-taken mode always falls through.
    assert_never_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (guess_mode == 2'b10 && fe_valid && !mispredict) |=> (fetch_pc == $past(fetch_pc) + STEP));

    // R9: mispredictions never outnumber resolved branches.
    assert_miss_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict_count <= branch_count);

endmodule

// File: tb/bp_frontend_bench.sv
// Bench: behavioural cycle model of the front end, compared on every clock.
module bp_frontend_bench;

    localparam int AW = 16;
    localparam int DW = 8;
    localparam int IB = 4;
    localparam int CW = 4;
    localparam logic [AW-1:0] RST_PC = 16'h0100;
    localparam int CNT_MAX = 15;
    localparam int RUN_CYCLES = 5000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    guess_mode = 2'b00;
    logic          fe_valid = 1'b0;
    logic          fe_is_branch = 1'b0;
    logic [DW-1:0] fe_disp = '0;
    logic          fe_hint_en = 1'b0;
    logic          fe_hint_dir = 1'b0;
    logic          ex_taken = 1'b0;
    logic [AW-1:0] fetch_pc, ex_pc, wb_pc, redirect_pc;
    logic          fetch_pred_taken, de_valid, ex_valid, ex_is_branch, wb_valid, flush;
    logic [CW-1:0] branch_count, mispredict_count;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    bp_frontend #(
        .ADDR_W(AW), .DISP_W(DW), .INSN_BYTES(IB), .CNT_W(CW), .RESET_PC(RST_PC)
    ) u_bp_frontend (
        .clk(clk), .rst_n(rst_n), .guess_mode(guess_mode),
        .fe_valid(fe_valid), .fe_is_branch(fe_is_branch), .fe_disp(fe_disp),
        .fe_hint_en(fe_hint_en), .fe_hint_dir(fe_hint_dir), .ex_taken(ex_taken),
        .fetch_pc(fetch_pc), .fetch_pred_taken(fetch_pred_taken),
        .de_valid(de_valid), .ex_valid(ex_valid), .ex_pc(ex_pc),
        .ex_is_branch(ex_is_branch), .wb_valid(wb_valid), .wb_pc(wb_pc),
        .flush(flush), .redirect_pc(redirect_pc),
        .branch_count(branch_count), .mispredict_count(mispredict_count)
    );

    // Reference model state: index 0 decode, 1 execute, 2 write-back.
    bit            mv   [3];
    logic [AW-1:0] mpc  [3];
    bit            mbr  [3];
    bit            mgs  [3];
    logic [AW-1:0] mtg  [3];
    logic [AW-1:0] mfpc;
    int            mb, mm;
    bit            prev_flush;
    bit            prev_flush_guess;
    bit            after_reset;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 3; i++) begin
            mv[i] = 0; mpc[i] = '0; mbr[i] = 0; mgs[i] = 0; mtg[i] = '0;
        end
        mfpc = RST_PC; mb = 0; mm = 0;
        prev_flush = 0; prev_flush_guess = 0; after_reset = 1;
    endtask

    // Registered outputs versus the model after the last clock edge.
    task automatic compare_state();
        string tv;
        tv = after_reset ? "R10" : (prev_flush ? (prev_flush_guess ? "R8" : "R6") : "R6");
        chk(after_reset ? "R10" : (prev_flush ? "R7" : "R4"), "fetch_pc", int'(fetch_pc), int'(mfpc));
        chk(tv, "de_valid", int'(de_valid), int'(mv[0]));
        chk(tv, "ex_valid", int'(ex_valid), int'(mv[1]));
        chk(tv, "wb_valid", int'(wb_valid), int'(mv[2]));
        if (mv[1]) chk("R5", "ex_pc", int'(ex_pc), int'(mpc[1]));
        if (mv[2]) chk("R6", "wb_pc", int'(wb_pc), int'(mpc[2]));
        chk(after_reset ? "R10" : "R9", "branch_count", int'(branch_count), mb);
        chk(after_reset ? "R10" : "R9", "mispredict_count", int'(mispredict_count), mm);
        after_reset = 0;
    endtask

    // One cycle: drive fetch and outcome from the model, check, advance the model.
    task automatic cycle(input int cyc);
        int h, d, tgt_i;
        bit v, br, he, hd, act, g, mis;
        logic [AW-1:0] tgt, redir;
        string gtag;
        compare_state();
        h  = int'(mfpc[AW-1:2]);
        v  = (cyc % 13) != 5;
        br = (h % 3) != 1;
        d  = (((h * 7) % 9) - 5) * 4;
        he = (h % 7) == 3;
        hd = h[1];
        act = $urandom_range(0, 1);
        fe_valid = v; fe_is_branch = br; fe_disp = DW'(d);
        fe_hint_en = he; fe_hint_dir = hd; ex_taken = act;
        #1;
        // Expected guess per mode.
        if (!(v && br)) begin g = 0; gtag = "R1"; end
        else if (guess_mode == 2'b01) begin g = 1; gtag = "R3"; end
        else if (guess_mode == 2'b10) begin g = 0; gtag = "R3"; end
        else if (he) begin g = hd; gtag = "R2"; end
        else begin g = (d <= 0); gtag = "R1"; end
        chk(gtag, "fetch_pred_taken", int'(fetch_pred_taken), int'(g));
        tgt_i = int'(mfpc) + d;
        tgt = AW'(tgt_i);
        mis = mv[1] && mbr[1] && (act != mgs[1]);
        chk("R5", "flush", int'(flush), int'(mis));
        redir = act ? mtg[1] : AW'(int'(mpc[1]) + IB);
        if (mis) chk("R7", "redirect_pc", int'(redirect_pc), int'(redir));
        // Counters.
        if (mv[1] && mbr[1] && mb < CNT_MAX) mb++;
        if (mis && mm < CNT_MAX) mm++;
        // Slot shift and squash.
        mv[2] = mv[1]; mpc[2] = mpc[1];
        if (mis) begin
            mv[1] = 0; mv[0] = 0;
            mfpc = redir;
        end else begin
            mv[1] = mv[0]; mpc[1] = mpc[0]; mbr[1] = mbr[0]; mgs[1] = mgs[0]; mtg[1] = mtg[0];
            mv[0] = v; mpc[0] = mfpc; mbr[0] = br; mgs[0] = g; mtg[0] = tgt;
            if (v) mfpc = g ? tgt : AW'(int'(mfpc) + IB);
        end
        prev_flush = mis;
        prev_flush_guess = mgs[1];
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        fe_valid = 1'b0;
        repeat (3) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(10 * 200000);
        n_bad++;
        $display("FAIL R5 watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        do_reset();
        for (int c = 0; c < RUN_CYCLES; c++) begin
            if (c == 2000) guess_mode = 2'b01;
            if (c == 3000) guess_mode = 2'b10;
            if (c == 4000) guess_mode = 2'b11;
            if (c == 2500) do_reset();
            cycle(c);
        end
        summary();
        $finish;
    end

endmodule